// File: doc/BRIEF.md
# Windowed Digital PLL Lock Detector

This block watches the two edge pulses a PLL phase detector sees: one from the reference divider and one from the feedback divider. For each pair it measures the gap in sampling-clock cycles. It then judges the pair as inside or outside a programmed window. A pair that fails resets progress at once. The lock flag rises only after a programmed number of consecutive passing pairs. The shortest possible lock time is therefore the lock count divided by the phase-detector rate. For example, 10000 pairs at 40 MHz take 250 µs.

A second run counter watches the same pass/fail stream against its own threshold, and decides when the loop may leave holdover. The block tracks the holdover state itself. It asks for holdover entry when lock drops, unless loss detection is disabled. It signals holdover exit once the exit count is reached while in holdover. Both requests are single-cycle pulses, and the surrounding clock logic acts on them.

Top module: `pll_lock_window_det`

## Requirements
- R1: `lock` stays low until `lock_thresh` consecutive in-window comparisons have completed, and is high no later than the second sampling edge after the edge that completes the last of them.
- R2: One out-of-window comparison clears both run counts, and a `lock` that was high drops within two sampling edges.
- R3: The separation is the number of sampling cycles between the two pulses, whichever pulse comes first. Pulses in the same cycle have separation 0. A separation equal to `win_cycles` passes, and `win_cycles`+1 fails.
- R4: An edge whose partner has not arrived within `win_cycles` cycles yields a failed comparison. So does a second edge of the same kind arriving while a partner is awaited.
- R5: Both run counts saturate at their threshold, so `lock` stays high through any number of further passing comparisons.
- R6: When `lock` falls, `hold_enter` pulses high for exactly one cycle on the next sampling edge and the block enters holdover. This happens only if `loss_hold_dis` is 0 and the block is not already in holdover. With `loss_hold_dis` = 1, no pulse occurs and no holdover is entered.
- R7: In holdover, once `hexit_thresh` consecutive in-window comparisons are reached, `hold_exit` pulses for one cycle and holdover ends. Outside holdover, reaching that count gives no pulse.
- R8: A threshold of 0 behaves as a threshold of 1.
- R9: After a synchronous active-low reset, `lock`, `hold_enter` and `hold_exit` are low and the block is not in holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per divided reference edge |
| fb_pulse | input | 1 | One-cycle pulse per divided feedback edge |
| win_cycles | input | WIN_W | Largest passing edge separation, in sampling cycles |
| lock_thresh | input | CNT_W | Consecutive passes needed for lock |
| hexit_thresh | input | CNT_W | Consecutive passes needed to leave holdover |
| loss_hold_dis | input | 1 | 1 suppresses holdover entry on loss of lock |
| lock | output | 1 | Lock indication |
| hold_enter | output | 1 | One-cycle request to enter holdover |
| hold_exit | output | 1 | One-cycle request to leave holdover |

## Verification
Suppose the pair timer judges a separation wrongly by one cycle, or does not time out a lone edge. Then `lock` rises or falls one comparison away from the expected point, which shows up within a few cycles of the offending pair. A run counter that wraps instead of saturating drops `lock` during a long run of passing pairs. A stale holdover flag shows as a missing or extra `hold_enter`/`hold_exit` pulse. This appears at the next loss of lock, or when the exit count is reached. The bench counts these pulses cumulatively and compares the counts after every comparison.

// File: rtl/pll_ld_pkg.sv
// Shared types for the windowed lock detector.
package pll_ld_pkg;
    // Pair timer state: idle, or awaiting the partner of a reference or feedback edge.
    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_WAIT_FB  = 2'd1,
        PAIR_WAIT_REF = 2'd2
    } pair_state_e;

    // One finished comparison: valid for one cycle, good when inside the window.
    typedef struct packed {
        logic valid;
        logic good;
    } cmp_res_t;
endpackage

// File: rtl/ld_edge_pair_timer.sv
// Measures the gap between a reference pulse and a feedback pulse in
// sampling cycles, whichever comes first, and emits one pass/fail result
// per pair. Assumes pulses are one cycle wide and synchronous to clk.
// A lone edge fails once the window has elapsed; a repeated edge of the
// same kind while waiting also fails and is consumed.
module ld_edge_pair_timer
    import pll_ld_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [WIN_W-1:0] win_cycles,
    output cmp_res_t         res
);
    localparam int ELAP_W = WIN_W + 1;

    pair_state_e       state, nxt_state;
    logic [ELAP_W-1:0] elap, nxt_elap;
    cmp_res_t          nxt_res;
    logic [ELAP_W-1:0] win_ext;
    logic              partner, same_kind;

    assign win_ext = {1'b0, win_cycles};

    // Next-state logic: start a pair, close it, or time it out.
    always_comb begin
        nxt_state = state;
        nxt_elap  = elap;
        nxt_res   = '0;
        partner   = (state == PAIR_WAIT_FB) ? fb_pulse  : ref_pulse;
        same_kind = (state == PAIR_WAIT_FB) ? ref_pulse : fb_pulse;
        case (state)
            PAIR_IDLE: begin
                if (ref_pulse && fb_pulse) begin
                    nxt_res.valid = 1'b1;
                    nxt_res.good  = 1'b1;
                end else if (ref_pulse) begin
                    nxt_state = PAIR_WAIT_FB;
                    nxt_elap  = ELAP_W'(1);
                end else if (fb_pulse) begin
                    nxt_state = PAIR_WAIT_REF;
                    nxt_elap  = ELAP_W'(1);
                end
            end
            default: begin
                if (partner) begin
                    nxt_res.valid = 1'b1;
                    nxt_res.good  = (elap <= win_ext);
                    nxt_state     = PAIR_IDLE;
                end else if (same_kind || (elap >= win_ext)) begin
                    nxt_res.valid = 1'b1;
                    nxt_res.good  = 1'b0;
                    nxt_state     = PAIR_IDLE;
                end else begin
                    nxt_elap = ELAP_W'(elap + 1'b1);
                end
            end
        endcase
    end

    // State, elapsed count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PAIR_IDLE;
            elap  <= '0;
            res   <= '0;
        end else begin
            state <= nxt_state;
            elap  <= nxt_elap;
            res   <= nxt_res;
        end
    end

    // R3
    same_cycle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_IDLE && ref_pulse && fb_pulse) |=> (res.valid && res.good));

    // R4
    repeat_edge_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_WAIT_FB && ref_pulse && !fb_pulse) |=> (res.valid && !res.good));
endmodule

// File: rtl/ld_run_counter.sv
// Counts consecutive passing comparisons up to a threshold and holds there.
// A failing comparison clears the count. Threshold 0 is treated as 1.
// Assumes the result input is valid for one cycle per comparison.
module ld_run_counter
    import pll_ld_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmp_res_t         res,
    input  logic [CNT_W-1:0] thresh,
    output logic             reached
);
    logic [CNT_W-1:0] run;
    logic [CNT_W-1:0] eff;

    assign eff     = (thresh == '0) ? CNT_W'(1) : thresh;
    assign reached = (run >= eff);

    // Run count: clear on a miss, step on a pass, clamp at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (res.valid) begin
            if (!res.good)
                run <= '0;
            else if (run >= eff)
                run <= eff;
            else
                run <= CNT_W'(run + 1'b1);
        end
    end

    // R2
    miss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res.valid && !res.good) |=> !reached);

    // R5
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !(res.valid && !res.good) && $stable(thresh)) |=> reached);
endmodule

// File: rtl/ld_hold_ctrl.sv
// Tracks the holdover state. Requests entry one cycle after lock falls,
// unless loss detection is disabled or holdover is already active. Requests
// exit once the exit run count is reached while in holdover. Assumes lock
// and the exit flag come from registered run counters.
module ld_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_now,
    input  logic exit_reached,
    input  logic loss_hold_dis,
    output logic hold_enter,
    output logic hold_exit
);
    logic lock_prev;
    logic in_hold;
    logic enter_cond;
    logic exit_cond;

    assign enter_cond = lock_prev && !lock_now && !loss_hold_dis && !in_hold;
    assign exit_cond  = in_hold && exit_reached;

    // Holdover flag and the single-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_prev  <= 1'b0;
            in_hold    <= 1'b0;
            hold_enter <= 1'b0;
            hold_exit  <= 1'b0;
        end else begin
            lock_prev  <= lock_now;
            hold_enter <= enter_cond;
            hold_exit  <= exit_cond;
            if (enter_cond)
                in_hold <= 1'b1;
            else if (exit_cond)
                in_hold <= 1'b0;
        end
    end

    // R6
    enter_respects_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_enter |-> !$past(loss_hold_dis));

    // R7
    exit_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_exit |-> !in_hold);

    // R6
    enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_enter |=> !hold_enter);

    // R7
    requests_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_enter && hold_exit));
endmodule

// File: rtl/pll_lock_window_det.sv
// Top of the windowed lock detector: one pair timer feeds two run counters
// (lock and holdover exit) that share the same window result, and a holdover
// controller turns their flags into entry and exit requests.
module pll_lock_window_det
    import pll_ld_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic [CNT_W-1:0] lock_thresh,
    input  logic [CNT_W-1:0] hexit_thresh,
    input  logic             loss_hold_dis,
    output logic             lock,
    output logic             hold_enter,
    output logic             hold_exit
);
    localparam int N_RUNS = 2;

    cmp_res_t                     cmp;
    logic [N_RUNS-1:0][CNT_W-1:0] thr_sel;
    logic [N_RUNS-1:0]            hit;

    assign thr_sel = {hexit_thresh, lock_thresh};

    ld_edge_pair_timer #(.WIN_W(WIN_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .fb_pulse   (fb_pulse),
        .win_cycles (win_cycles),
        .res        (cmp)
    );

    for (genvar g = 0; g < N_RUNS; g++) begin : g_run
        ld_run_counter #(.CNT_W(CNT_W)) u_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .res     (cmp),
            .thresh  (thr_sel[g]),
            .reached (hit[g])
        );
    end

    assign lock = hit[0];

    ld_hold_ctrl u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_now      (hit[0]),
        .exit_reached  (hit[1]),
        .loss_hold_dis (loss_hold_dis),
        .hold_enter    (hold_enter),
        .hold_exit     (hold_exit)
    );

    // R1
    lock_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(cmp.valid && cmp.good));
endmodule

// File: tb/pll_lock_window_det_tb.sv
// Scoreboard bench: driver tasks issue edge pairs, update a requirement-level
// model and push the expected port state; a monitor pops and compares.
module pll_lock_window_det_tb;
    localparam int WIN_W = 8;
    localparam int CNT_W = 16;
    localparam int WIN   = 3;

    typedef struct {
        logic  lk;
        int    n_en;
        int    n_ex;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0;
    logic [WIN_W-1:0] win_cycles = WIN_W'(WIN);
    logic [CNT_W-1:0] lock_thresh = 16'd4, hexit_thresh = 16'd6;
    logic loss_hold_dis = 1'b0;
    logic lock, hold_enter, hold_exit;

    int checks = 0, errors = 0;
    int cnt_en = 0, cnt_ex = 0;
    int m_run = 0, m_hx = 0, m_en = 0, m_ex = 0;
    bit m_lock = 0, m_hold = 0;
    bit done = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pll_lock_window_det #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .win_cycles(win_cycles), .lock_thresh(lock_thresh), .hexit_thresh(hexit_thresh),
        .loss_hold_dis(loss_hold_dis), .lock(lock), .hold_enter(hold_enter),
        .hold_exit(hold_exit)
    );

    // Count request pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && hold_enter) cnt_en++;
        if (rst_n && hold_exit)  cnt_ex++;
    end

    function automatic int eff(input logic [CNT_W-1:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    // Model of R1, R2, R5..R8 for one completed comparison.
    task automatic model(input bit good);
        bit was = m_lock;
        m_run  = good ? ((m_run >= eff(lock_thresh)) ? eff(lock_thresh) : m_run + 1) : 0;
        m_hx   = good ? ((m_hx >= eff(hexit_thresh)) ? eff(hexit_thresh) : m_hx + 1) : 0;
        m_lock = (m_run >= eff(lock_thresh));
        if (was && !m_lock && !loss_hold_dis && !m_hold) begin
            m_en++;
            m_hold = 1;
        end else if (m_hold && m_hx >= eff(hexit_thresh)) begin
            m_ex++;
            m_hold = 0;
        end
    endtask

    task automatic push(input string tag);
        exp_t e;
        repeat (4) @(negedge clk);
        #1;
        e.lk = m_lock; e.n_en = m_en; e.n_ex = m_ex; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Pair with a given separation; ref_first picks which edge leads.
    task automatic pair(input int gap, input bit ref_first, input string tag);
        @(negedge clk);
        if (gap == 0) begin ref_pulse = 1; fb_pulse = 1; end
        else if (ref_first) ref_pulse = 1;
        else fb_pulse = 1;
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
        if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            if (ref_first) fb_pulse = 1; else ref_pulse = 1;
            @(negedge clk);
            ref_pulse = 0; fb_pulse = 0;
        end
        model(gap <= WIN);
        push(tag);
    endtask

    // Lone reference edge that never gets a partner.
    task automatic orphan(input string tag);
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        repeat (WIN + 2) @(negedge clk);
        model(0);
        push(tag);
    endtask

    // Two reference edges with no feedback edge between them.
    task automatic double_ref(input string tag);
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        @(negedge clk); ref_pulse = 1;
        @(negedge clk); ref_pulse = 0;
        model(0);
        push(tag);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare against the ports.
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            cmp(e.tag, "lock", int'(lock), int'(e.lk));
            cmp(e.tag, "enter_count", cnt_en, e.n_en);
            cmp(e.tag, "exit_count", cnt_ex, e.n_ex);
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        cmp("R9", "lock", int'(lock), 0);
        cmp("R9", "hold_enter", int'(hold_enter), 0);
        cmp("R9", "hold_exit", int'(hold_exit), 0);

        for (int i = 0; i < 4; i++) pair(2, 1, "R1");
        pair(0, 1, "R3_same_cycle");
        pair(WIN, 0, "R3_fb_first_edge_of_window");
        pair(WIN + 1, 1, "R2_R3_R6_window_plus_one");
        for (int i = 0; i < 6; i++) pair(i % 3, i[0], "R7_exit_in_hold");
        for (int i = 0; i < 20; i++) pair(1, 1, "R5_saturate");
        orphan("R4_orphan");
        for (int i = 0; i < 6; i++) pair(2, 0, "R7_second_exit");
        loss_hold_dis = 1;
        double_ref("R4_R6_repeat_edge_dis");
        for (int i = 0; i < 6; i++) pair(1, 1, "R7_no_exit_outside_hold");
        loss_hold_dis = 0;
        pair(WIN + 2, 0, "R6_enter_again");
        lock_thresh = 16'd0;
        pair(1, 1, "R8_zero_thresh");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule